// File: doc/BRIEF.md
# Debounced GPIO Group Interrupt

This block merges the interrupt requests of a group of general-purpose pins into one active-high request line. The request line suits an edge-triggered interrupt input on a legacy system bus. Each pin has three controls: a direction bit, a polarity-invert bit and an interrupt-enable bit. A pin takes part only when it is an input and its enable is set. The level it contributes is the one seen after the polarity adjustment.

A single debounce-enable bit covers the whole group. When it is set, every pin goes through a digital filter clocked by an external tick of about one millisecond. A pulse too short to cover two consecutive ticks never reaches the output, so mechanical switches and push-buttons can be wired straight to the pins. When the bit is clear, the adjusted level goes straight to the OR. The group output is registered, which adds one clock cycle of latency.

Top module: `gpio_grp_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irq` is 0. Every filtered state clears to 0.
- R2: With debounce off, `irq` equals, one clock later, the OR of `(pin_in ^ pin_inv) & pin_ie & pin_is_in` over all pins.
- R3: A pin whose `pin_ie` bit is 0 never asserts `irq`, whatever its level.
- R4: A pin whose `pin_is_in` bit is 0 (output) never asserts `irq`, whatever its level.
- R5: When `pin_inv` is 1, the pin requests on its low level. When `pin_inv` is 0, it requests on its high level.
- R6: With debounce off, a change at an enabled input pin shows at `irq` on the next rising clock edge, with no tick needed.
- R7: With debounce on, a pin's filtered state takes a new adjusted level only on a `tick`. That happens on the second consecutive `tick` during which the adjusted level differs from the filtered state. A pulse that covers at most one tick is rejected.
- R8: With debounce on, a return to the inactive level is filtered the same way, so a short dropout does not clear `irq`.
- R9: While debounce is off, each filtered state tracks its adjusted input, so turning debounce back on causes no spurious request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, about 1 ms apart |
| dbnc_en | input | 1 | Group debounce enable |
| pin_in | input | NPIN | Raw pin levels |
| pin_is_in | input | NPIN | 1 = pin configured as input |
| pin_inv | input | NPIN | 1 = invert pin polarity |
| pin_ie | input | NPIN | 1 = pin interrupt enabled |
| irq | output | 1 | Group interrupt request, active high |

## Verification
The hardest situation to reach is a pulse whose length sits just around the tick spacing. Such a pulse covers exactly one tick and so must be dropped, while a slightly longer one covers two ticks and must pass. The bench produces its own tick at a fixed cycle spacing. It times the pulses against that spacing, so short pulses and dropouts cover no more than one tick and long levels cover at least three. A behavioural per-pin tick counter in the bench decides the expected output on every clock.

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq #(
  parameter int NPIN      = 8,
  parameter int TICKS_REQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            dbnc_en,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_is_in,
  input  logic [NPIN-1:0] pin_inv,
  input  logic [NPIN-1:0] pin_ie,
  output logic            irq
);
  localparam int CNT_W = $clog2(TICKS_REQ + 1);

  logic [NPIN-1:0] adj, filt_q, eff;
  logic irq_q;

  assign adj = pin_in ^ pin_inv;
  assign eff = dbnc_en ? filt_q : adj;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic             f_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q   <= 1'b0;
        cnt_q <= '0;
      end else if (!dbnc_en) begin
        f_q   <= adj[i];
        cnt_q <= '0;
      end else if (adj[i] == f_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == CNT_W'(TICKS_REQ - 1)) begin
          f_q   <= adj[i];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign filt_q[i] = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(eff & pin_ie & pin_is_in);
  end

  assign irq = irq_q;
endmodule

module gpio_grp_irq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            dbnc_en,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] pin_is_in,
  input logic [NPIN-1:0] pin_inv,
  input logic [NPIN-1:0] pin_ie,
  input logic [NPIN-1:0] filt,
  input logic            irq
);
  assert_rst_clear_R1: assert property (@(posedge clk) !rst_n |-> (!irq && filt == '0));

  assert_no_member_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_ie & pin_is_in) == '0) |=> !irq);

  assert_direct_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbnc_en && ((pin_in ^ pin_inv) & pin_ie & pin_is_in) != '0) |=> irq);

  assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_en && !tick) |=> $stable(filt));
endmodule

bind gpio_grp_irq gpio_grp_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dbnc_en(dbnc_en),
  .pin_in(pin_in), .pin_is_in(pin_is_in), .pin_inv(pin_inv),
  .pin_ie(pin_ie), .filt(filt_q), .irq(irq)
);

// File: tb/gpio_grp_irq_tb.sv
`timescale 1ns/1ps
module gpio_grp_irq_tb;
  localparam int N  = 8;
  localparam int TP = 20;

  logic clk = 0, rst_n = 0, tick = 0, dbnc_en = 0;
  logic [N-1:0] pin_in = '0, pin_is_in = '0, pin_inv = '0, pin_ie = '0;
  logic irq;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0;
  string cur_req = "R1";
  bit m_f [N];
  int m_c [N];
  bit m_irq = 0;
  bit saw_hi, saw_lo;

  always #2 clk = ~clk;

  gpio_grp_irq #(.NPIN(N), .TICKS_REQ(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbnc_en(dbnc_en),
    .pin_in(pin_in), .pin_is_in(pin_is_in), .pin_inv(pin_inv),
    .pin_ie(pin_ie), .irq(irq)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, evaluated on the values held before each edge
  always @(posedge clk) begin
    bit any;
    any = 0;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_f[i] = 0; m_c[i] = 0; end
      m_irq = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit a;
        a = pin_in[i] ^ pin_inv[i];
        if ((dbnc_en ? m_f[i] : a) && pin_ie[i] && pin_is_in[i]) any = 1;
        if (!dbnc_en) begin m_f[i] = a; m_c[i] = 0; end
        else if (a == m_f[i]) m_c[i] = 0;
        else if (tick) begin
          m_c[i]++;
          if (m_c[i] >= 2) begin m_f[i] = a; m_c[i] = 0; end
        end
      end
      m_irq = any;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) chk(irq, m_irq, cur_req);
    if (irq) saw_hi = 1; else saw_lo = 1;
    tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog irq=%0b expected=finish", irq);
      summary();
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_seen();
    saw_hi = 0; saw_lo = 0;
  endtask

  initial begin
    wait_cyc(3);
    chk(irq, 0, "R1");
    rst_n = 1;
    wait_cyc(1);
    chk(irq, 0, "R1");

    cur_req = "R2";
    pin_ie = '1; pin_is_in = '1;
    pin_in = 8'h08;
    wait_cyc(1);
    chk(irq, 1, "R6");
    pin_in = 8'h81;
    wait_cyc(2);
    chk(irq, 1, "R2");
    pin_in = 8'h00;
    wait_cyc(2);
    chk(irq, 0, "R2");

    cur_req = "R3";
    pin_ie = 8'hF7; pin_in = 8'h08;
    wait_cyc(3);
    chk(irq, 0, "R3");
    pin_ie = '0; pin_in = '1;
    wait_cyc(3);
    chk(irq, 0, "R3");

    cur_req = "R4";
    pin_ie = '1; pin_is_in = 8'hDF; pin_in = 8'h20;
    wait_cyc(3);
    chk(irq, 0, "R4");
    pin_is_in = '1;
    wait_cyc(2);
    chk(irq, 1, "R4");

    cur_req = "R5";
    pin_in = 8'h00; pin_ie = 8'h20; pin_inv = 8'h20;
    wait_cyc(2);
    chk(irq, 1, "R5");
    pin_in = 8'h20;
    wait_cyc(2);
    chk(irq, 0, "R5");
    pin_inv = 8'h00; pin_in = 8'h00; pin_ie = '1;
    wait_cyc(2);

    cur_req = "R7";
    dbnc_en = 1;
    wait_cyc(2 * TP);
    clr_seen();
    pin_in = 8'h04;
    wait_cyc(TP / 2 + 5);
    pin_in = 8'h00;
    wait_cyc(3 * TP);
    chk(saw_hi, 0, "R7");
    pin_in = 8'h04;
    wait_cyc(TP / 2);
    chk(irq, 0, "R7");
    wait_cyc(3 * TP);
    chk(irq, 1, "R7");

    cur_req = "R8";
    clr_seen();
    pin_in = 8'h00;
    wait_cyc(TP / 2 + 5);
    pin_in = 8'h04;
    wait_cyc(3 * TP);
    chk(saw_lo, 0, "R8");
    pin_in = 8'h00;
    wait_cyc(4 * TP);
    chk(irq, 0, "R8");

    cur_req = "R9";
    dbnc_en = 0;
    pin_in = 8'h40;
    wait_cyc(2);
    chk(irq, 1, "R9");
    pin_in = 8'h00;
    wait_cyc(1);
    dbnc_en = 1;
    clr_seen();
    wait_cyc(3 * TP);
    chk(saw_hi, 0, "R9");

    for (int k = 0; k < 6; k++) begin
      pin_in = 8'(k * 37);
      pin_inv = 8'(k * 11);
      wait_cyc(TP * (k % 3) + 7);
    end
    dbnc_en = 0;
    wait_cyc(10);

    cur_req = "R1";
    rst_n = 0;
    wait_cyc(1);
    chk(irq, 0, "R1");
    rst_n = 1;
    wait_cyc(2);

    summary();
    $finish;
  end
endmodule